// File: doc/BRIEF.md
# Tiny In-Order Integer Core

A minimal three-stage integer processor. A fetch stage reads an internal instruction store, a read stage pulls operands from a 128-entry register file, and an execute stage computes the result and writes it back at the end of the same cycle. The instruction set has five operations: register add and subtract, add and subtract with an immediate, and a branch taken when two registers differ.

A new instruction is fetched every cycle in straight-line code. There is no branch prediction. Once a branch is seen, fetch issues nothing until the branch has computed its next PC. A result is forwarded from execute into the read stage, so an instruction that reads a register written by the instruction just ahead of it gets the new value without stalling.

A program is written into the instruction store through a load port while reset is held. After reset is released, the core runs until the PC reaches or passes the highest loaded address plus one. It then raises a halt flag. A debug port reads any register, with one cycle of latency.

Top module: `tiny_core`

## Requirements
- R1: While reset is high, the PC and every register are cleared to 0. After reset with no register writes, a debug read of any register returns 0.
- R2: An instruction word has the opcode in bits [31:29], rd in [28:22], rs in [21:15], rt in [14:8] and a signed immediate in [7:0]. Opcode 0 (ADD) writes rd = rs + rt and opcode 1 (SUB) writes rd = rs - rt, both wrapping at 32 bits.
- R3: Opcode 2 (ADDI) writes rd = rs + sext(imm) and opcode 3 (SUBI) writes rd = rs - sext(imm). Immediates from -128 to 127 are honoured.
- R4: Opcode 4 (BNE) compares rs and rt and writes nothing. If they differ, the next PC is the branch PC + 1 + sext(imm). Otherwise it is the branch PC + 1.
- R5: After a BNE is fetched, no further instruction is fetched until it resolves. An instruction on the skipped path never writes a register.
- R6: An instruction reading a register written by the instruction directly before it sees the new value. The same holds at any greater distance.
- R7: The halt flag rises once the PC is at or beyond the program length and the pipeline holds no instruction. It stays high until the next reset, and all writes are complete when it rises.
- R8: dbg_data shows the register selected by dbg_addr one clock edge after dbg_addr is presented.
- R9: Load-port writes take effect only while reset is high. Each reset pulse restarts the program length, which becomes the highest loaded address + 1.
- R10: Opcodes 5, 6 and 7 are no-ops: they write no register and do not redirect fetch.
- R11: In straight-line code of N instructions, take edge 0 as the first clock edge that samples reset low. The halt flag is low after edge N+1 and high after edge N+2, which means one instruction is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables program loading |
| ld_we | input | 1 | Instruction store write enable (honoured only during reset) |
| ld_addr | input | 7 | Instruction store write address |
| ld_data | input | 32 | Instruction word to store |
| dbg_addr | input | 7 | Register index for the debug read |
| dbg_data | output | 32 | Registered contents of the selected register |
| halted | output | 1 | Program finished and pipeline drained |

## Verification
Internal faults show up at the ports in three ways. A wrong forward, a wrong branch target or a write that leaks from the skipped path leaves a register value that differs from what sequential execution gives. This shows as soon as the register file is swept through the debug port after halt. A fetch that stalls too long or too briefly moves the edge on which halt rises, and that edge is checked exactly for straight-line code. A wrong program length or a load that leaks in while running changes which instructions execute, and that again appears in the final register sweep.

// File: rtl/tiny_core_pkg.sv
`timescale 1ns/1ps
package tiny_core_pkg;
  localparam int OPC_W = 3;
  localparam logic [OPC_W-1:0] OP_ADD  = 3'd0;
  localparam logic [OPC_W-1:0] OP_SUB  = 3'd1;
  localparam logic [OPC_W-1:0] OP_ADDI = 3'd2;
  localparam logic [OPC_W-1:0] OP_SUBI = 3'd3;
  localparam logic [OPC_W-1:0] OP_BNE  = 3'd4;

  function automatic logic op_writes(input logic [OPC_W-1:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADDI) || (op == OP_SUBI);
  endfunction
endpackage

// File: rtl/tiny_core_exec.sv
`timescale 1ns/1ps
module tiny_core_exec
  import tiny_core_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              valid,
  input  logic [OPC_W-1:0]  op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] res,
  output logic              we,
  output logic              taken
);
  always_comb begin
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_ADDI: res = a + imm;
      OP_SUBI: res = a - imm;
      default: res = '0;
    endcase
  end

  assign we    = valid && op_writes(op);
  assign taken = valid && (op == OP_BNE) && (a != b);
endmodule

// File: rtl/tiny_core_regs.sv
`timescale 1ns/1ps
module tiny_core_regs #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [REG_AW-1:0] ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [REG_AW-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_data,
  input  logic [REG_AW-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_data
);
  localparam int NREG = 1 << REG_AW;

  logic [DATA_W-1:0] mem [NREG];

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
      dbg_data <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      dbg_data <= mem[dbg_addr];
    end
  end
endmodule

// File: rtl/tiny_core_fetch.sv
`timescale 1ns/1ps
module tiny_core_fetch #(
  parameter int PC_AW   = 7,
  parameter int INSTR_W = 32,
  localparam int PCW    = PC_AW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_we,
  input  logic [PC_AW-1:0]   ld_addr,
  input  logic [INSTR_W-1:0] ld_data,
  input  logic               hold,
  input  logic               redirect,
  input  logic [PCW-1:0]     redirect_pc,
  output logic               f_valid,
  output logic [INSTR_W-1:0] f_inst,
  output logic [PC_AW-1:0]   f_pc,
  output logic [PCW-1:0]     pc,
  output logic [PCW-1:0]     prog_len
);
  localparam int DEPTH = 1 << PC_AW;

  logic [INSTR_W-1:0] imem [DEPTH];
  logic [PCW-1:0]     len_q = '0;
  logic               rst_q = 1'b0;
  logic [PCW-1:0]     len_base;
  logic [PCW-1:0]     ld_end;
  logic               fire;

  assign len_base = rst_q ? len_q : '0;
  assign ld_end   = {1'b0, ld_addr} + PCW'(1);
  assign fire     = !rst && !hold && (pc < len_q);
  assign prog_len = len_q;

  // instruction store: single write port, registered read with enable
  always_ff @(posedge clk) begin
    if (rst && ld_we) imem[ld_addr] <= ld_data;
    if (fire) f_inst <= imem[pc[PC_AW-1:0]];
  end

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) len_q <= (ld_we && ld_end > len_base) ? ld_end : len_base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      f_valid <= 1'b0;
      f_pc    <= '0;
    end else begin
      f_valid <= fire;
      if (fire) f_pc <= pc[PC_AW-1:0];
      if (redirect)  pc <= redirect_pc;
      else if (fire) pc <= pc + PCW'(1);
    end
  end
endmodule

// File: rtl/tiny_core.sv
`timescale 1ns/1ps
module tiny_core
  import tiny_core_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_AW  = 7,
  parameter int PC_AW   = 7,
  parameter int IMM_W   = 8,
  localparam int INSTR_W = OPC_W + 3 * REG_AW + IMM_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_we,
  input  logic [PC_AW-1:0]   ld_addr,
  input  logic [INSTR_W-1:0] ld_data,
  input  logic [REG_AW-1:0]  dbg_addr,
  output logic [DATA_W-1:0]  dbg_data,
  output logic               halted
);
  localparam int PCW    = PC_AW + 1;
  localparam int RD_LSB = INSTR_W - OPC_W - REG_AW;
  localparam int RS_LSB = RD_LSB - REG_AW;
  localparam int RT_LSB = RS_LSB - REG_AW;

  // fetch stage outputs
  logic               f_valid;
  logic [INSTR_W-1:0] f_inst;
  logic [PC_AW-1:0]   f_pc;
  logic [PCW-1:0]     fetch_pc;
  logic [PCW-1:0]     prog_len;

  // decoded fields of the fetched word
  logic [OPC_W-1:0]  f_op;
  logic [REG_AW-1:0] f_rd, f_rs, f_rt;
  logic [IMM_W-1:0]  f_imm;
  assign f_op  = f_inst[INSTR_W-1 -: OPC_W];
  assign f_rd  = f_inst[RD_LSB +: REG_AW];
  assign f_rs  = f_inst[RS_LSB +: REG_AW];
  assign f_rt  = f_inst[RT_LSB +: REG_AW];
  assign f_imm = f_inst[IMM_W-1:0];

  // read-stage result register
  logic              d_valid;
  logic [OPC_W-1:0]  d_op;
  logic [REG_AW-1:0] d_rd;
  logic [DATA_W-1:0] d_a, d_b;
  logic [IMM_W-1:0]  d_imm;
  logic [PC_AW-1:0]  d_pc;

  // execute signals
  logic [DATA_W-1:0] ex_res;
  logic              ex_we;
  logic              ex_taken;
  logic [DATA_W-1:0] ex_imm;

  logic [DATA_W-1:0] rf_a, rf_b, op_a, op_b;
  logic              f_bne, d_bne;
  logic [PCW-1:0]    seq_pc, br_pc, next_pc;

  assign f_bne = f_valid && (f_op == OP_BNE);
  assign d_bne = d_valid && (d_op == OP_BNE);

  tiny_core_fetch #(.PC_AW(PC_AW), .INSTR_W(INSTR_W)) fetch_i (
    .clk(clk), .rst(rst),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .hold(f_bne || d_bne), .redirect(d_bne), .redirect_pc(next_pc),
    .f_valid(f_valid), .f_inst(f_inst), .f_pc(f_pc),
    .pc(fetch_pc), .prog_len(prog_len)
  );

  tiny_core_regs #(.DATA_W(DATA_W), .REG_AW(REG_AW)) regs_i (
    .clk(clk), .rst(rst),
    .we(ex_we), .waddr(d_rd), .wdata(ex_res),
    .ra_addr(f_rs), .ra_data(rf_a),
    .rb_addr(f_rt), .rb_data(rf_b),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  // execute-to-read forwarding: the only in-flight writer is one stage ahead
  assign op_a = (ex_we && d_rd == f_rs) ? ex_res : rf_a;
  assign op_b = (ex_we && d_rd == f_rt) ? ex_res : rf_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      d_valid <= 1'b0;
      d_op    <= '0;
      d_rd    <= '0;
      d_a     <= '0;
      d_b     <= '0;
      d_imm   <= '0;
      d_pc    <= '0;
    end else begin
      d_valid <= f_valid;
      d_op    <= f_op;
      d_rd    <= f_rd;
      d_a     <= op_a;
      d_b     <= op_b;
      d_imm   <= f_imm;
      d_pc    <= f_pc;
    end
  end

  assign ex_imm = DATA_W'($signed(d_imm));

  tiny_core_exec #(.DATA_W(DATA_W)) exec_i (
    .valid(d_valid), .op(d_op), .a(d_a), .b(d_b), .imm(ex_imm),
    .res(ex_res), .we(ex_we), .taken(ex_taken)
  );

  assign seq_pc  = {1'b0, d_pc} + PCW'(1);
  assign br_pc   = seq_pc + PCW'($signed(d_imm));
  assign next_pc = ex_taken ? br_pc : seq_pc;

  always_ff @(posedge clk) begin
    if (rst) halted <= 1'b0;
    else if (!f_valid && !d_valid && fetch_pc >= prog_len) halted <= 1'b1;
  end
endmodule

// File: rtl/tiny_core_chk.sv
`timescale 1ns/1ps
module tiny_core_chk #(
  parameter int PCW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [PCW-1:0] pc,
  input logic           f_valid,
  input logic           f_bne,
  input logic           d_valid,
  input logic           d_bne,
  input logic [2:0]     d_op,
  input logic           rf_we,
  input logic           halted
);
  // R1: the PC starts at zero when reset drops
  p_pc_cleared_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pc == '0);

  // R5: nothing is fetched behind a branch in the fetch stage
  p_shadow_fetch_r5: assert property (@(posedge clk) disable iff (rst)
    f_bne |=> !f_valid);

  // R5: nothing is fetched while a branch resolves
  p_shadow_resolve_r5: assert property (@(posedge clk) disable iff (rst)
    d_bne |-> !f_valid);

  // R7: halt is sticky
  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R7: the pipeline is empty while halted
  p_halt_drained_r7: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!f_valid && !d_valid));

  // R10: undefined opcodes never write a register
  p_noop_silent_r10: assert property (@(posedge clk) disable iff (rst)
    (d_valid && d_op > 3'd4) |-> !rf_we);
endmodule

bind tiny_core tiny_core_chk #(.PCW(PCW)) chk_i (
  .clk(clk), .rst(rst), .pc(fetch_pc),
  .f_valid(f_valid), .f_bne(f_bne),
  .d_valid(d_valid), .d_bne(d_bne), .d_op(d_op),
  .rf_we(ex_we), .halted(halted)
);

// File: tb/tiny_core_tb_top.sv
`timescale 1ns/1ps
module tiny_core_tb_top;
  localparam int DW = 32, RAW = 7, PAW = 7, IW = 32;
  localparam int NREG = 1 << RAW, NPC = 1 << PAW;

  logic clk = 1'b0, rst = 1'b1, ld_we = 1'b0;
  logic [PAW-1:0] ld_addr = '0;
  logic [IW-1:0]  ld_data = '0;
  logic [RAW-1:0] dbg_addr = '0;
  logic [DW-1:0]  dbg_data;
  logic           halted;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;

  logic [IW-1:0] prog [NPC];
  int            plen;
  logic [DW-1:0] mref [NREG];

  always #2.5 clk = ~clk;

  tiny_core dut_i (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data), .halted(halted)
  );

  function automatic logic [IW-1:0] enc(input logic [2:0] op, input int rd,
                                        input int rs, input int rt, input int imm);
    return {op, 7'(rd), 7'(rs), 7'(rt), 8'(imm)};
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // sequential ISA model of the loaded program
  task automatic run_model();
    int pc = 0;
    int steps = 0;
    for (int i = 0; i < NREG; i++) mref[i] = '0;
    while (pc >= 0 && pc < plen && steps < 20000) begin
      logic [IW-1:0] w;
      logic [DW-1:0] simm;
      int rd, rs, rt, ioff;
      w    = prog[pc];
      rd   = int'(w[28:22]);
      rs   = int'(w[21:15]);
      rt   = int'(w[14:8]);
      simm = {{24{w[7]}}, w[7:0]};
      ioff = int'($signed(w[7:0]));
      steps++;
      case (w[31:29])
        3'd0: begin mref[rd] = mref[rs] + mref[rt]; pc++; end
        3'd1: begin mref[rd] = mref[rs] - mref[rt]; pc++; end
        3'd2: begin mref[rd] = mref[rs] + simm; pc++; end
        3'd3: begin mref[rd] = mref[rs] - simm; pc++; end
        3'd4: pc = (mref[rs] != mref[rt]) ? pc + 1 + ioff : pc + 1;
        default: pc++;
      endcase
    end
  endtask

  // reset, load prog[0..plen-1], release reset on a falling edge
  task automatic load_and_start();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < plen; i++) begin
      ld_we = 1'b1; ld_addr = PAW'(i); ld_data = prog[i];
      @(negedge clk);
    end
    ld_we = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_halt(input string tag);
    for (int i = 0; i < 4000; i++) begin
      if (halted) break;
      @(negedge clk);
    end
    chk(tag, DW'(halted), DW'(1));
  endtask

  task automatic read_reg(input int r, output logic [DW-1:0] v);
    @(negedge clk) dbg_addr = RAW'(r);
    @(negedge clk) v = dbg_data;
  endtask

  task automatic sweep(input string tag);
    logic [DW-1:0] v;
    for (int r = 0; r < NREG; r++) begin
      read_reg(r, v);
      chk($sformatf("%s reg%0d", tag, r), v, mref[r]);
    end
  endtask

  task automatic spot(input string tag, input int r, input logic [DW-1:0] exp);
    logic [DW-1:0] v;
    read_reg(r, v);
    chk(tag, v, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    // ---- program A: doubling loop with a backward branch (R2 R4 R6 R9)
    plen = 11;
    prog[0]  = enc(3'd2, 5, 0, 0, 1);
    prog[1]  = enc(3'd2, 20, 0, 0, 64);
    prog[2]  = enc(3'd0, 5, 5, 5, 0);
    prog[3]  = enc(3'd0, 6, 5, 5, 0);
    prog[4]  = enc(3'd4, 0, 5, 20, -3);
    prog[5]  = enc(3'd0, 7, 6, 6, 0);
    prog[6]  = enc(3'd0, 8, 7, 7, 0);
    prog[7]  = enc(3'd0, 9, 8, 8, 0);
    prog[8]  = enc(3'd0, 10, 9, 9, 0);
    prog[9]  = enc(3'd3, 11, 10, 0, 50);
    prog[10] = enc(3'd1, 12, 11, 5, 0);
    load_and_start();
    chk("R7 halt low after start", DW'(halted), DW'(0));
    // R9: a load while running must be ignored
    ld_we = 1'b1; ld_addr = 7'd9; ld_data = enc(3'd2, 11, 0, 0, 77);
    @(negedge clk) ld_we = 1'b0;
    run_model();
    wait_halt("R7 halt after loop");
    spot("R4 loop exit r5", 5, 32'd64);
    spot("R6 chain r12", 12, 32'd1934);
    spot("R9 running load ignored r11", 11, 32'd1998);
    sweep("R2 R4 R6 progA");

    // ---- program B: forwarding, wrap, immediates, branch forms, no-ops
    plen = 20;
    prog[0]  = enc(3'd2, 2, 0, 0, 4);
    prog[1]  = enc(3'd2, 3, 0, 0, 5);
    prog[2]  = enc(3'd2, 1, 0, 0, 2);
    prog[3]  = enc(3'd0, 1, 2, 3, 0);
    prog[4]  = enc(3'd0, 4, 1, 1, 0);
    prog[5]  = enc(3'd3, 40, 0, 0, 1);
    prog[6]  = enc(3'd2, 41, 40, 0, 1);
    prog[7]  = enc(3'd0, 42, 40, 40, 0);
    prog[8]  = enc(3'd2, 43, 0, 0, -128);
    prog[9]  = enc(3'd3, 44, 0, 0, -128);
    prog[10] = enc(3'd2, 45, 0, 0, 127);
    prog[11] = enc(3'd4, 0, 1, 1, 2);
    prog[12] = enc(3'd2, 50, 0, 0, 7);
    prog[13] = enc(3'd4, 0, 1, 2, 1);
    prog[14] = enc(3'd2, 51, 0, 0, 9);
    prog[15] = enc(3'd2, 52, 0, 0, 3);
    prog[16] = enc(3'd1, 53, 52, 45, 0);
    prog[17] = enc(3'd5, 54, 52, 52, 1);
    prog[18] = enc(3'd7, 55, 52, 52, 1);
    prog[19] = enc(3'd4, 0, 52, 0, 100);
    load_and_start();
    run_model();
    wait_halt("R7 halt after forward branch out");
    spot("R6 back-to-back r1", 1, 32'd9);
    spot("R6 forwarded r4", 4, 32'd18);
    spot("R2 wrap r41", 41, 32'd0);
    spot("R3 imm -128 r43", 43, 32'hFFFF_FF80);
    spot("R3 subi -128 r44", 44, 32'd128);
    spot("R4 not taken r50", 50, 32'd7);
    spot("R5 skipped path r51", 51, 32'd0);
    spot("R10 no-op r54", 54, 32'd0);
    sweep("R2 R3 R5 progB");

    // ---- program C: single no-op; reset clears everything (R1 R10 R11)
    plen = 1;
    prog[0] = enc(3'd6, 5, 1, 1, 3);
    load_and_start();
    for (int k = 0; k <= 2; k++) @(posedge clk);
    @(negedge clk);
    chk("R11 halt low at edge N+1", DW'(halted), DW'(0));
    @(posedge clk);
    @(negedge clk);
    chk("R11 halt high at edge N+2", DW'(halted), DW'(1));
    @(negedge clk);
    chk("R7 halt held", DW'(halted), DW'(1));
    run_model();
    sweep("R1 R8 cleared");

    // ---- program D: 20 straight-line dependent ADDIs (R11 R6)
    plen = 20;
    for (int i = 0; i < 20; i++) prog[i] = enc(3'd2, i + 1, i, 0, i + 1);
    load_and_start();
    for (int k = 0; k <= 21; k++) @(posedge clk);
    @(negedge clk);
    chk("R11 straight halt low", DW'(halted), DW'(0));
    @(posedge clk);
    @(negedge clk);
    chk("R11 straight halt high", DW'(halted), DW'(1));
    run_model();
    spot("R6 chain sum r20", 20, 32'd210);
    sweep("R6 R11 progD");

    finish_run();
  end
endmodule